// File: doc/BRIEF.md
# Nibble Accumulator ALU Slice

This block is a 4-bit accumulator register with a small arithmetic and logic unit in front of it. On every rising clock edge the accumulator is reloaded with the result of one operation. A 4-bit opcode selects the operation. Each operation uses the current accumulator value and a 4-bit operand supplied from outside the block. Eight opcodes carry defined operations. The other eight are spare, and all of them keep the accumulator unchanged so that a stray code can never corrupt it.

The adder's carry-out is presented combinationally. It shows the carry that the operation selected on the inputs at that moment would produce. This lets a neighbouring slice or an indicator see the overflow before the edge that commits the result. The datapath width is a parameter with a default of 4. A second parameter selects either an explicit ripple-carry adder or a behavioural one.

Top module: `nibble_acc_alu`

## Requirements
- R1: While rst_n is low the accumulator reads 0, immediately and on every clock edge; the first edge after rst_n rises applies the opcode to that 0.
- R2: Opcode 0 (hold) and every opcode from 8 to 15 leave the accumulator unchanged at the edge.
- R3: Opcode 1 loads the accumulator shifted right by one place, with 0 entering bit 3 and bit 0 dropped.
- R4: Opcode 2 loads (A + B) mod 16.
- R5: Opcode 3 loads (A + B + 1) mod 16, with the extra one entering through the adder carry-in.
- R6: Opcode 4 loads (A + 1) mod 16.
- R7: Opcode 5 loads the bitwise inverse of A.
- R8: Opcode 6 loads 0.
- R9: Opcode 7 loads (NOT A) OR B, bit by bit.
- R10: The carry output equals bit 4 of the unwrapped sum for opcodes 2, 3 and 4 (A+B, A+B+1, A+1), and is 0 for every other opcode.
- R11: The accumulator changes only at a rising clock edge; opcode and operand changes between edges have no effect until the next edge, where only the values present at that edge count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the accumulator loads on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset, clears the accumulator |
| opcode | input | 4 | Operation select, codes 0 to 15 |
| b | input | 4 | External operand B |
| a | output | 4 | Current accumulator value |
| carry | output | 1 | Adder carry-out of the selected operation, combinational |

## Verification
Reset and an accumulator load can fall in the same cycle. The bench provokes this by pulling rst_n low while increment is selected on a non-zero accumulator. It judges the result by requiring 0 immediately and after the next edge, then one edge after release. The carry output and the register load also share a cycle. For every opcode and every pair of A and B values, the carry is judged before the edge against the pending operation, and the register is judged after the edge against a model of the eight operations and the spare codes.

// File: rtl/nacc_pkg.sv
package nacc_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OP_HOLD  = 4'd0,
      OP_SHR   = 4'd1,
      OP_ADD   = 4'd2,
      OP_ADDC  = 4'd3,
      OP_INC   = 4'd4,
      OP_INV   = 4'd5,
      OP_CLR   = 4'd6,
      OP_IMPLY = 4'd7
   } nacc_op_e;

endpackage

// File: rtl/nacc_adder.sv
module nacc_adder #(
   parameter int W      = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);

   generate
      if (RIPPLE) begin : g_ripple
         logic [W:0] c;
         assign c[0] = cin;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]  = x[i] ^ y[i] ^ c[i];
            assign c[i+1]  = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
         end
         assign cout = c[W];
      end else begin : g_behav
         logic [W:0] full;
         assign full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
         assign sum  = full[W-1:0];
         assign cout = full[W];
      end
   endgenerate

endmodule

// File: rtl/nacc_opunit.sv
module nacc_opunit
   import nacc_pkg::*;
#(
   parameter int W      = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0]     acc,
   input  logic [W-1:0]     opnd,
   input  logic [OPC_W-1:0] op,
   output logic [W-1:0]     nxt,
   output logic             cout
);

   logic [W-1:0] add_y;
   logic         add_cin;
   logic [W-1:0] add_sum;
   logic         add_cout;
   logic         is_arith;

   always_comb begin
      add_y    = opnd;
      add_cin  = 1'b0;
      is_arith = 1'b0;
      case (op)
         OP_ADD:  begin is_arith = 1'b1; end
         OP_ADDC: begin is_arith = 1'b1; add_cin = 1'b1; end
         OP_INC:  begin is_arith = 1'b1; add_cin = 1'b1; add_y = '0; end
         default: ;
      endcase
   end

   nacc_adder #(.W(W), .RIPPLE(RIPPLE)) u_add (
      .x    (acc),
      .y    (add_y),
      .cin  (add_cin),
      .sum  (add_sum),
      .cout (add_cout)
   );

   always_comb begin
      case (op)
         OP_SHR:   nxt = {1'b0, acc[W-1:1]};
         OP_ADD,
         OP_ADDC,
         OP_INC:   nxt = add_sum;
         OP_INV:   nxt = ~acc;
         OP_CLR:   nxt = '0;
         OP_IMPLY: nxt = ~acc | opnd;
         default:  nxt = acc;
      endcase
   end

   assign cout = is_arith & add_cout;

endmodule

// File: rtl/nacc_accreg.sv
module nacc_accreg #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

endmodule

// File: rtl/nibble_acc_alu.sv
module nibble_acc_alu
   import nacc_pkg::*;
#(
   parameter int WIDTH  = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPC_W-1:0] opcode,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] a,
   output logic             carry
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("nibble_acc_alu: WIDTH must be at least 2");
      end
      if (OPC_W < 3) begin : g_bad_opc
         $error("nibble_acc_alu: opcode field too narrow for eight operations");
      end
   endgenerate

   logic [WIDTH-1:0] next_val;

   nacc_opunit #(.W(WIDTH), .RIPPLE(RIPPLE)) u_ops (
      .acc  (a),
      .opnd (b),
      .op   (opcode),
      .nxt  (next_val),
      .cout (carry)
   );

   nacc_accreg #(.W(WIDTH)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (next_val),
      .q     (a)
   );

endmodule

// File: rtl/nacc_checker.sv
module nacc_checker
   import nacc_pkg::*;
#(
   parameter int W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [OPC_W-1:0] opcode,
   input logic [W-1:0]     b,
   input logic [W-1:0]     a,
   input logic             carry
);

   p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> a == '0);

   p_hold_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == OP_HOLD || opcode[OPC_W-1]) |=> $stable(a));

   p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
      opcode == OP_SHR |=> a == ($past(a) >> 1));

   p_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
      opcode == OP_ADD |=> a == W'($past(a) + $past(b)));

   p_addc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      opcode == OP_ADDC |=> a == W'($past(a) + $past(b) + 1'b1));

   p_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      opcode == OP_INC |=> a == W'($past(a) + 1'b1));

   p_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
      opcode == OP_INV |=> a == ~$past(a));

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      opcode == OP_CLR |=> a == '0);

   p_imply_r9: assert property (@(posedge clk) disable iff (!rst_n)
      opcode == OP_IMPLY |=> a == (~$past(a) | $past(b)));

   p_carry_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(opcode == OP_ADD || opcode == OP_ADDC || opcode == OP_INC) |-> !carry);

endmodule

bind nibble_acc_alu nacc_checker #(.W(WIDTH)) u_chk (.*);

// File: tb/nibble_acc_alu_test.sv
module nibble_acc_alu_test;
   timeunit 1ns;
   timeprecision 1ps;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] opcode = 4'd0;
   logic [3:0] b = 4'd0;
   logic [3:0] a;
   logic       carry;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   nibble_acc_alu uut (
      .clk    (clk),
      .rst_n  (rst_n),
      .opcode (opcode),
      .b      (b),
      .a      (a),
      .carry  (carry)
   );

   function automatic string req_of(int op);
      case (op)
         1: return "R3";
         2: return "R4";
         3: return "R5";
         4: return "R6";
         5: return "R7";
         6: return "R8";
         7: return "R9";
         default: return "R2";
      endcase
   endfunction

   function automatic logic [3:0] model_a(int op, int av, int bv);
      case (op)
         1: return 4'(av / 2);
         2: return 4'(av + bv);
         3: return 4'(av + bv + 1);
         4: return 4'(av + 1);
         5: return 4'(15 - av);
         6: return 4'd0;
         7: return 4'((15 - av) | bv);
         default: return 4'(av);
      endcase
   endfunction

   function automatic logic model_c(int op, int av, int bv);
      case (op)
         2: return (av + bv) > 15;
         3: return (av + bv + 1) > 15;
         4: return (av + 1) > 15;
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(string req, int got, int exp, string what);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
      end
   endtask

   // Bring the accumulator to v via clear then add; returns at a negedge.
   task automatic load_a(int v);
      opcode = 4'd6; b = 4'd0;
      @(negedge clk);
      opcode = 4'd2; b = 4'(v);
      @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1", a, 0, "a during reset");
      check("R10", carry, 0, "carry during reset with hold");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", a, 0, "a after release with hold");
   endtask

   task automatic t_all_ops();
      for (int op = 0; op < 16; op++) begin
         for (int av = 0; av < 16; av++) begin
            for (int bv = 0; bv < 16; bv++) begin
               load_a(av);
               opcode = 4'(op); b = 4'(bv);
               #1;
               check("R10", carry, model_c(op, av, bv), $sformatf("carry op=%0d a=%0d b=%0d", op, av, bv));
               @(negedge clk);
               check(req_of(op), a, model_a(op, av, bv), $sformatf("a op=%0d a=%0d b=%0d", op, av, bv));
            end
         end
      end
   endtask

   task automatic t_reset_vs_load();
      load_a(9);
      opcode = 4'd4; rst_n = 1'b0;
      #1;
      check("R1", a, 0, "async clear while inc selected");
      @(negedge clk);
      check("R1", a, 0, "reset wins over inc at edge");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", a, 1, "first edge after release applies inc to 0");
   endtask

   task automatic t_between_edges();
      load_a(5);
      opcode = 4'd4; b = 4'd3;
      #3;
      check("R11", a, 5, "no change before edge with inc");
      opcode = 4'd6;
      #2;
      check("R11", a, 5, "no change before edge with clear");
      opcode = 4'd0; b = 4'd15;
      @(negedge clk);
      check("R11", a, 5, "only opcode at edge counts");
      opcode = 4'd5;
      @(negedge clk);
      check("R7", a, 10, "invert after mid-cycle test");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_reset_vs_load();
      t_between_edges();
      t_all_ops();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule